// File: doc/BRIEF.md
# Byte-to-Word Bus Bridge

This block lets an 8-bit processor bus reach a peripheral whose data path is 16 bits wide, such as a disk-drive style register file. The processor addresses each 16-bit word as two consecutive bytes, the even byte (address bit 0 clear) holding bits 7:0 and the odd byte holding bits 15:8. It must touch them in ascending order. The bridge holds one half of the word in a holding register, so each word access reaches the device only once.

On a write, the even byte goes into a low holding register. The odd byte then goes straight to device bits 15:8 while the held byte drives bits 7:0, together with a write strobe. On a read, the even byte fires the device read strobe. It returns device bits 7:0 and parks bits 15:8 in a high holding register, which the odd-byte read returns without any device cycle. Address bit 4 picks one of two device chip selects.

The design is fully synchronous and built around a five-state machine. `ST_IDLE` is the state with no access. `ST_WR_LO`, `ST_WR_HI`, `ST_RD_LO` and `ST_RD_HI` are the four access kinds. At every rising edge the state moves to the access kind decoded from read/write and address bit 0 when the select is high, and to `ST_IDLE` when it is low. Any state can move to any state. Each access therefore lasts one cycle, and it starts in the cycle after the select was sampled.

Top module: `byte_word_bridge`

## Requirements
- R1: After a synchronous reset, all device strobes, both chip selects, the output enable, `cpu_rdata` and `dev_wdata` are 0. Both holding registers are 0, so an odd-byte read returns 0 and an odd-byte write drives 0 on bits 7:0.
- R2: In a cycle that follows a cycle where `sel` was sampled low, no strobe, chip select or output enable is active, and `cpu_rdata` is 0.
- R3: A write (`rd_nwr`=0) with `a0`=0 only loads `cpu_wdata` into the low holding register. It raises no strobe and no output enable.
- R4: A write with `a0`=1 raises `dev_wr_stb` and `dev_oe` for one cycle. In that cycle `dev_wdata[15:8]` is the new byte and `dev_wdata[7:0]` is the most recently written even byte.
- R5: A read (`rd_nwr`=1) with `a0`=0 raises `dev_rd_stb` for one cycle and returns `dev_rdata[7:0]` on `cpu_rdata` in that cycle. At the end of that cycle it loads `dev_rdata[15:8]` into the high holding register.
- R6: A read with `a0`=1 returns the high holding register on `cpu_rdata` and raises no device strobe.
- R7: With `CS_XFER_ONLY`=0, every selected access asserts `dev_cs0` when `a4`=0 and `dev_cs1` when `a4`=1. The two selects are never active together.
- R8: With `CS_XFER_ONLY`=1, a chip select is asserted only in a cycle that carries `dev_rd_stb` or `dev_wr_stb`. It is still picked by `a4`.
- R9: `dev_oe` is asserted only together with `dev_wr_stb`, and `dev_rd_stb` and `dev_wr_stb` are never active together.
- R10: Outputs for an access appear exactly one cycle after `sel` is sampled. Back-to-back selects give back-to-back single-cycle accesses, and a holding register loaded by one access is visible to the next.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sel | input | 1 | Bridge select, sampled at the rising edge |
| rd_nwr | input | 1 | 1 = read, 0 = write |
| a0 | input | 1 | Byte lane: 0 = bits 7:0, 1 = bits 15:8 |
| a4 | input | 1 | Chip select choice |
| cpu_wdata | input | BYTE_W | Processor write byte |
| cpu_rdata | output | BYTE_W | Processor read byte, valid in the access cycle |
| dev_wdata | output | 2*BYTE_W | Device write word |
| dev_oe | output | 1 | Drive enable for the device data bus |
| dev_rdata | input | 2*BYTE_W | Device read word |
| dev_cs0 | output | 1 | Device chip select 0 |
| dev_cs1 | output | 1 | Device chip select 1 |
| dev_rd_stb | output | 1 | Device read strobe, one cycle |
| dev_wr_stb | output | 1 | Device write strobe, one cycle |

## Verification
The bench builds two copies with the default 8-bit byte width, one with `CS_XFER_ONLY`=0 and one with `CS_XFER_ONLY`=1, and drives both with the same stimulus. This puts both chip-select policies side by side on each access. It sweeps every combination of read/write, `a0` and `a4` over several data patterns, with an idle cycle after each access. It also runs back-to-back pairs, so the holding registers are seen both after a gap and in the very next cycle.

// File: rtl/bwb_pkg.sv
package bwb_pkg;
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_WR_LO = 3'd1,
        ST_WR_HI = 3'd2,
        ST_RD_LO = 3'd3,
        ST_RD_HI = 3'd4
    } bwb_state_e;
endpackage

// File: rtl/bwb_decode.sv
module bwb_decode
    import bwb_pkg::*;
(
    input  logic       sel,
    input  logic       rd_nwr,
    input  logic       a0,
    output bwb_state_e nxt
);
    always_comb begin
        nxt = ST_IDLE;
        if (sel) begin
            unique case ({rd_nwr, a0})
                2'b00: nxt = ST_WR_LO;
                2'b01: nxt = ST_WR_HI;
                2'b10: nxt = ST_RD_LO;
                2'b11: nxt = ST_RD_HI;
            endcase
        end
    end
endmodule

// File: rtl/bwb_hold_regs.sv
module bwb_hold_regs #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_lo,
    input  logic [BYTE_W-1:0] lo_in,
    input  logic              ld_hi,
    input  logic [BYTE_W-1:0] hi_in,
    output logic [BYTE_W-1:0] lo_q,
    output logic [BYTE_W-1:0] hi_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            lo_q <= '0;
            hi_q <= '0;
        end else begin
            if (ld_lo) lo_q <= lo_in;
            if (ld_hi) hi_q <= hi_in;
        end
    end
endmodule

// File: rtl/bwb_cs_sel.sv
module bwb_cs_sel #(
    parameter bit CS_XFER_ONLY = 1'b0
) (
    input  logic active,
    input  logic xfer,
    input  logic pick,
    output logic cs0,
    output logic cs1
);
    logic gate;
    generate
        if (CS_XFER_ONLY) begin : g_xfer
            assign gate = active & xfer;
        end else begin : g_any
            assign gate = active;
        end
    endgenerate
    assign cs0 = gate & ~pick;
    assign cs1 = gate & pick;
endmodule

// File: rtl/byte_word_bridge.sv
module byte_word_bridge
    import bwb_pkg::*;
#(
    parameter int BYTE_W       = 8,
    parameter bit CS_XFER_ONLY = 1'b0
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                sel,
    input  logic                rd_nwr,
    input  logic                a0,
    input  logic                a4,
    input  logic [BYTE_W-1:0]   cpu_wdata,
    output logic [BYTE_W-1:0]   cpu_rdata,
    output logic [2*BYTE_W-1:0] dev_wdata,
    output logic                dev_oe,
    input  logic [2*BYTE_W-1:0] dev_rdata,
    output logic                dev_cs0,
    output logic                dev_cs1,
    output logic                dev_rd_stb,
    output logic                dev_wr_stb
);
    localparam int WORD_W = 2 * BYTE_W;

    bwb_state_e        state_q, state_d;
    logic [BYTE_W-1:0] wbyte_q;
    logic              a4_q;
    logic [BYTE_W-1:0] hold_lo, hold_hi;
    logic              ld_lo, ld_hi, active, xfer;

    bwb_decode u_dec (
        .sel    (sel),
        .rd_nwr (rd_nwr),
        .a0     (a0),
        .nxt    (state_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            wbyte_q <= '0;
            a4_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            if (sel) begin
                wbyte_q <= cpu_wdata;
                a4_q    <= a4;
            end
        end
    end

    always_comb begin
        cpu_rdata  = '0;
        dev_wdata  = '0;
        dev_oe     = 1'b0;
        dev_rd_stb = 1'b0;
        dev_wr_stb = 1'b0;
        ld_lo      = 1'b0;
        ld_hi      = 1'b0;
        active     = 1'b1;
        unique case (state_q)
            ST_IDLE:  active = 1'b0;
            ST_WR_LO: ld_lo = 1'b1;
            ST_WR_HI: begin
                dev_wdata  = {wbyte_q, hold_lo};
                dev_oe     = 1'b1;
                dev_wr_stb = 1'b1;
            end
            ST_RD_LO: begin
                cpu_rdata  = dev_rdata[BYTE_W-1:0];
                dev_rd_stb = 1'b1;
                ld_hi      = 1'b1;
            end
            ST_RD_HI: cpu_rdata = hold_hi;
            default:  active = 1'b0;
        endcase
        xfer = dev_rd_stb | dev_wr_stb;
    end

    bwb_hold_regs #(.BYTE_W(BYTE_W)) u_hold (
        .clk   (clk),
        .rst   (rst),
        .ld_lo (ld_lo),
        .lo_in (wbyte_q),
        .ld_hi (ld_hi),
        .hi_in (dev_rdata[WORD_W-1:BYTE_W]),
        .lo_q  (hold_lo),
        .hi_q  (hold_hi)
    );

    bwb_cs_sel #(.CS_XFER_ONLY(CS_XFER_ONLY)) u_cs (
        .active (active),
        .xfer   (xfer),
        .pick   (a4_q),
        .cs0    (dev_cs0),
        .cs1    (dev_cs1)
    );
endmodule

// File: rtl/byte_word_bridge_chk.sv
module byte_word_bridge_chk #(
    parameter int BYTE_W       = 8,
    parameter bit CS_XFER_ONLY = 1'b0
) (
    input logic                clk,
    input logic                rst,
    input logic                sel,
    input logic                rd_nwr,
    input logic                a0,
    input logic                a4,
    input logic [BYTE_W-1:0]   cpu_wdata,
    input logic [BYTE_W-1:0]   cpu_rdata,
    input logic [2*BYTE_W-1:0] dev_wdata,
    input logic                dev_oe,
    input logic                dev_cs0,
    input logic                dev_cs1,
    input logic                dev_rd_stb,
    input logic                dev_wr_stb
);
    logic past_ok;
    always_ff @(posedge clk) past_ok <= !rst;

    assert_idle_after_nosel_R2: assert property (@(posedge clk) disable iff (rst || !past_ok)
        !$past(sel) |-> !(dev_rd_stb || dev_wr_stb || dev_oe || dev_cs0 || dev_cs1) && cpu_rdata == '0);

    assert_wrlo_quiet_R3: assert property (@(posedge clk) disable iff (rst || !past_ok)
        $past(sel && !rd_nwr && !a0) |-> !dev_wr_stb && !dev_rd_stb && !dev_oe);

    assert_wrhi_strobe_R4: assert property (@(posedge clk) disable iff (rst || !past_ok)
        $past(sel && !rd_nwr && a0) |-> dev_wr_stb && dev_oe
            && dev_wdata[2*BYTE_W-1:BYTE_W] == $past(cpu_wdata));

    assert_rdlo_strobe_R5: assert property (@(posedge clk) disable iff (rst || !past_ok)
        $past(sel && rd_nwr && !a0) |-> dev_rd_stb && !dev_wr_stb);

    assert_rdhi_quiet_R6: assert property (@(posedge clk) disable iff (rst || !past_ok)
        $past(sel && rd_nwr && a0) |-> !dev_rd_stb && !dev_wr_stb && !dev_oe);

    assert_cs_onehot_R7: assert property (@(posedge clk) disable iff (rst)
        $onehot0({dev_cs0, dev_cs1}));

    assert_cs_pick_R7: assert property (@(posedge clk) disable iff (rst || !past_ok)
        (!CS_XFER_ONLY && $past(sel)) |-> dev_cs1 == $past(a4) && dev_cs0 == !$past(a4));

    assert_cs_xfer_only_R8: assert property (@(posedge clk) disable iff (rst)
        (CS_XFER_ONLY && (dev_cs0 || dev_cs1)) |-> (dev_rd_stb || dev_wr_stb));

    assert_oe_with_wr_R9: assert property (@(posedge clk) disable iff (rst)
        dev_oe |-> dev_wr_stb);

    assert_strobe_excl_R9: assert property (@(posedge clk) disable iff (rst)
        !(dev_rd_stb && dev_wr_stb));
endmodule

bind byte_word_bridge byte_word_bridge_chk #(.BYTE_W(BYTE_W), .CS_XFER_ONLY(CS_XFER_ONLY)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .sel        (sel),
    .rd_nwr     (rd_nwr),
    .a0         (a0),
    .a4         (a4),
    .cpu_wdata  (cpu_wdata),
    .cpu_rdata  (cpu_rdata),
    .dev_wdata  (dev_wdata),
    .dev_oe     (dev_oe),
    .dev_cs0    (dev_cs0),
    .dev_cs1    (dev_cs1),
    .dev_rd_stb (dev_rd_stb),
    .dev_wr_stb (dev_wr_stb)
);

// File: tb/tb_byte_word_bridge.sv
module tb_byte_word_bridge;
    localparam int CLK_PERIOD = 10;
    localparam int BW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          sel = 1'b0, rd_nwr = 1'b0, a0 = 1'b0, a4 = 1'b0;
    logic [BW-1:0] cpu_wdata = '0;
    logic [2*BW-1:0] dev_rdata = '0;

    logic [BW-1:0]   rdata_a, rdata_b;
    logic [2*BW-1:0] wdata_a, wdata_b;
    logic oe_a, cs0_a, cs1_a, rs_a, ws_a;
    logic oe_b, cs0_b, cs1_b, rs_b, ws_b;

    int checks = 0;
    int fails  = 0;
    logic [BW-1:0] exp_lo = '0, exp_hi = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    byte_word_bridge #(.BYTE_W(BW), .CS_XFER_ONLY(1'b0)) dut (
        .clk(clk), .rst(rst), .sel(sel), .rd_nwr(rd_nwr), .a0(a0), .a4(a4),
        .cpu_wdata(cpu_wdata), .cpu_rdata(rdata_a), .dev_wdata(wdata_a), .dev_oe(oe_a),
        .dev_rdata(dev_rdata), .dev_cs0(cs0_a), .dev_cs1(cs1_a),
        .dev_rd_stb(rs_a), .dev_wr_stb(ws_a)
    );

    byte_word_bridge #(.BYTE_W(BW), .CS_XFER_ONLY(1'b1)) dut_xfer (
        .clk(clk), .rst(rst), .sel(sel), .rd_nwr(rd_nwr), .a0(a0), .a4(a4),
        .cpu_wdata(cpu_wdata), .cpu_rdata(rdata_b), .dev_wdata(wdata_b), .dev_oe(oe_b),
        .dev_rdata(dev_rdata), .dev_cs0(cs0_b), .dev_cs1(cs1_b),
        .dev_rd_stb(rs_b), .dev_wr_stb(ws_b)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic chk_quiet(input string req);
        chk({rs_a, ws_a, oe_a, cs0_a, cs1_a} == 5'b0, req, {rs_a, ws_a, oe_a, cs0_a, cs1_a}, 0);
        chk({rs_b, ws_b, oe_b, cs0_b, cs1_b} == 5'b0, req, {rs_b, ws_b, oe_b, cs0_b, cs1_b}, 0);
        chk(rdata_a == '0, req, rdata_a, 0);
    endtask

    // checks the outputs of the access whose select was sampled one edge earlier
    task automatic chk_access(input logic r, input logic b0, input logic b4,
                              input logic [BW-1:0] wd, input logic [2*BW-1:0] dd);
        logic xf;
        xf = (!r && b0) || (r && !b0);
        // R7: any-access chip select policy
        chk(cs0_a == !b4 && cs1_a == b4, "R7", {cs0_a, cs1_a}, {!b4, b4});
        // R8: transfer-only chip select policy
        chk(cs0_b == (xf && !b4) && cs1_b == (xf && b4), "R8", {cs0_b, cs1_b}, {xf && !b4, xf && b4});
        // R9: output enable only with write strobe, strobes exclusive
        chk((oe_a == ws_a) && !(rs_a && ws_a), "R9", {oe_a, ws_a, rs_a}, {ws_a, ws_a, 1'b0});
        unique case ({r, b0})
            2'b00: begin
                chk({rs_a, ws_a, oe_a} == 3'b0, "R3", {rs_a, ws_a, oe_a}, 0);
                exp_lo = wd;
            end
            2'b01: begin
                chk(ws_a && oe_a && !rs_a, "R4", {rs_a, ws_a, oe_a}, 3'b011);
                chk(wdata_a == {wd, exp_lo}, "R4", wdata_a, {wd, exp_lo});
                chk(wdata_b == {wd, exp_lo}, "R4", wdata_b, {wd, exp_lo});
            end
            2'b10: begin
                chk(rs_a && !ws_a && !oe_a, "R5", {rs_a, ws_a, oe_a}, 3'b100);
                chk(rdata_a == dd[BW-1:0], "R5", rdata_a, dd[BW-1:0]);
                exp_hi = dd[2*BW-1:BW];
            end
            2'b11: begin
                chk({rs_a, ws_a, oe_a} == 3'b0, "R6", {rs_a, ws_a, oe_a}, 0);
                chk(rdata_a == exp_hi, "R6", rdata_a, exp_hi);
                chk(rdata_b == exp_hi, "R6", rdata_b, exp_hi);
            end
        endcase
    endtask

    task automatic drive(input logic r, input logic b0, input logic b4,
                         input logic [BW-1:0] wd, input logic [2*BW-1:0] dd);
        sel = 1'b1; rd_nwr = r; a0 = b0; a4 = b4; cpu_wdata = wd; dev_rdata = dd;
    endtask

    // one access followed by one idle cycle
    task automatic access_gap(input logic r, input logic b0, input logic b4,
                              input logic [BW-1:0] wd, input logic [2*BW-1:0] dd);
        @(negedge clk); drive(r, b0, b4, wd, dd);
        @(negedge clk); chk_access(r, b0, b4, wd, dd);
        sel = 1'b0; cpu_wdata = ~wd; rd_nwr = ~r; a0 = ~b0;
        @(negedge clk); chk_quiet("R2");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk_quiet("R1");
        chk(wdata_a == '0, "R1", wdata_a, 0);
        access_gap(1'b1, 1'b1, 1'b0, 8'h00, 16'hffff);   // R1: hold-high is zero
        access_gap(1'b0, 1'b1, 1'b1, 8'h5a, 16'h0000);   // R1: hold-low is zero
        // sweep: every kind, both chip selects, several patterns
        for (int p = 0; p < 6; p++) begin
            for (int k = 0; k < 8; k++) begin
                logic [BW-1:0]   wd;
                logic [2*BW-1:0] dd;
                wd = BW'(8'h11 * (p + 1) + k * 8'h25);
                dd = 16'(16'h1357 * (p + 3) + k * 16'h0f1e);
                access_gap(k[2], k[1], k[0], wd, dd);
            end
        end
        // R10: back-to-back write pair, then back-to-back read pair
        for (int p = 0; p < 4; p++) begin
            logic [BW-1:0]   w1, w2;
            logic [2*BW-1:0] dd;
            w1 = BW'(8'h3c + p * 8'h41);
            w2 = BW'(8'hc3 - p * 8'h17);
            dd = 16'(16'ha55a + p * 16'h1111);
            @(negedge clk); drive(1'b0, 1'b0, p[0], w1, dd);
            @(negedge clk); chk_access(1'b0, 1'b0, p[0], w1, dd);
            drive(1'b0, 1'b1, p[1], w2, dd);
            @(negedge clk); chk_access(1'b0, 1'b1, p[1], w2, dd);
            chk(wdata_a[BW-1:0] == w1, "R10", wdata_a[BW-1:0], w1);
            drive(1'b1, 1'b0, p[0], w2, dd);
            @(negedge clk); chk_access(1'b1, 1'b0, p[0], w2, dd);
            drive(1'b1, 1'b1, p[1], w2, dd);
            @(negedge clk); chk_access(1'b1, 1'b1, p[1], w2, dd);
            chk(rdata_a == dd[2*BW-1:BW], "R10", rdata_a, dd[2*BW-1:BW]);
            sel = 1'b0;
            @(negedge clk); chk_quiet("R10");
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 100000, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule